// File: doc/BRIEF.md
# TLB Entry Register File

This block holds the software-visible entry registers of two translation lookaside buffers, one for data accesses and one for instruction fetches. Each entry is a pair of words: a match word, whose bit 0 is the entry's valid flag and whose upper bits carry the page tag, and a translate word that holds the physical mapping. Software reaches both through the special-purpose register space. A 16-bit register number splits into a 5-bit group (bits 15:11) and an 11-bit offset (bits 10:0). Group 1 selects the data TLB and group 2 selects the instruction TLB.

Inside either group, offsets 512 to 639 form the match window and offsets 640 to 767 form the translate window. The entry index is the offset minus the base of its window, and only the first `ENTRIES` indexes of each window are backed by storage. Offsets 768 to 1535 address the additional ways. They are decoded but hold nothing: a write there is dropped, and a read returns the destination's prior value (`acc_prev`), just as it does for any address the block does not map.

A write that clears the valid bit of a match word invalidates the page the entry used to map. The block reports this one cycle later with a single-cycle strobe. The strobe carries the entry's old match word with bits 12:0 cleared (8 KiB pages) and a flag naming which TLB the entry belongs to. A small state machine produces the strobe. It has two states: `INV_IDLE` (no strobe) and `INV_PULSE` (strobe high). Its transitions are:
- `T_FIRE`: `INV_IDLE` to `INV_PULSE`, on an invalidating write.
- `T_REFIRE`: `INV_PULSE` to `INV_PULSE`, on another invalidating write in the strobe cycle.
- `T_DONE`: `INV_PULSE` to `INV_IDLE`, when there is no such write.
- `T_HOLD`: `INV_IDLE` to `INV_IDLE`, when there is no such write.

Top module: `tlbreg_access`

## Requirements
- R1: After reset, every valid bit (bit 0 of every match word, in both TLBs) reads 0, and no invalidate strobe is raised.
- R2: Group 1 addresses only the data TLB and group 2 only the instruction TLB. A write in one group never changes a value read back from the other.
- R3: Offsets 512 to 512+ENTRIES-1 address match word (offset-512). A write takes effect at the clock edge, and a read returns the stored word combinationally in the same cycle.
- R4: Offsets 640 to 640+ENTRIES-1 address translate word (offset-640). Writes and reads behave as in R3.
- R5: Offsets 768 to 1535 (the extra ways), unbacked window indexes ENTRIES to 127, all other offsets, and all groups other than 1 and 2 store nothing. A read of any of them returns `acc_prev`.
- R6: A write to a match word with bit 0 equal to 0 raises `inv_valid` for exactly the following cycle. A second such write in that cycle extends the strobe by one more cycle.
- R7: `inv_page` equals the match word held before the invalidating write, with bits 12:0 cleared.
- R8: `inv_instr` is 1 when the invalidated entry belongs to the instruction TLB (group 2) and 0 for the data TLB (group 1).
- R9: Match writes with bit 0 equal to 1, translate writes, and writes to addresses covered by R5 raise no strobe.
- R10: While `acc_valid` is 0, nothing is written, no strobe is raised, and `acc_rdata` equals `acc_prev`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Register access this cycle |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 16 | Register number: group in bits 15:11, offset in bits 10:0 |
| acc_wdata | input | DATA_W | Write data |
| acc_prev | input | DATA_W | Prior value of the destination, returned for unmapped reads |
| acc_rdata | output | DATA_W | Read data (combinational) |
| inv_valid | output | 1 | Page-invalidate strobe |
| inv_page | output | DATA_W | Page-aligned old match word of the invalidated entry |
| inv_instr | output | 1 | 1 = instruction TLB, 0 = data TLB |

## Verification
Some behaviours are checked by the assertions on every cycle:
- each stored word lands at the index that was written;
- every invalidating write produces the strobe on the next cycle, and every other cycle is strobe-free;
- the strobed page is aligned, and the flag follows the selected TLB;
- unmapped reads pass `acc_prev` through.

Other behaviours only the bench's scenarios can show. These include the exact offset-to-index arithmetic over both full groups, the absence of aliasing between the two TLBs, and the fact that writes to the extra ways leave every backed word untouched. The bench also establishes that the strobed page is the value held before the write rather than the new one, and that a back-to-back invalidation stretches the strobe.

// File: rtl/tlbreg_pkg.sv
package tlbreg_pkg;

    // Register number layout: {group[4:0], offset[10:0]}
    localparam int ADDR_W    = 16;
    localparam int OFF_W     = 11;
    localparam int GRP_W     = 5;

    localparam logic [GRP_W-1:0] GRP_DATA  = 5'd1;
    localparam logic [GRP_W-1:0] GRP_INSTR = 5'd2;

    localparam logic [OFF_W-1:0] MATCH_BASE = 11'd512;
    localparam logic [OFF_W-1:0] XLATE_BASE = 11'd640;
    localparam logic [OFF_W-1:0] EXTRA_LO   = 11'd768;
    localparam logic [OFF_W-1:0] EXTRA_HI   = 11'd1535;
    localparam logic [OFF_W-1:0] WIN_SPAN   = 11'd128;

    typedef enum logic [1:0] {
        KIND_NONE  = 2'd0,
        KIND_MATCH = 2'd1,
        KIND_XLATE = 2'd2,
        KIND_EXTRA = 2'd3
    } reg_kind_e;

    typedef enum logic {
        INV_IDLE  = 1'b0,
        INV_PULSE = 1'b1
    } inv_state_e;

endpackage

// File: rtl/tlbreg_decode.sv
module tlbreg_decode
    import tlbreg_pkg::*;
#(
    parameter int ENTRIES = 128,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_kind_e         kind,
    output logic              sel_instr,
    output logic [IDX_W-1:0]  idx
);

    localparam logic [OFF_W-1:0] ENT_L = OFF_W'(ENTRIES);

    logic [GRP_W-1:0] grp;
    logic [OFF_W-1:0] off;
    logic [OFF_W-1:0] rel_m;
    logic [OFF_W-1:0] rel_x;
    logic             in_grp;

    always_comb begin
        grp       = addr[ADDR_W-1 -: GRP_W];
        off       = addr[OFF_W-1:0];
        in_grp    = (grp == GRP_DATA) || (grp == GRP_INSTR);
        sel_instr = (grp == GRP_INSTR);
        rel_m     = off - MATCH_BASE;
        rel_x     = off - XLATE_BASE;
        kind      = KIND_NONE;
        idx       = '0;
        if (in_grp) begin
            if (off >= MATCH_BASE && off < XLATE_BASE) begin
                if (rel_m < ENT_L) begin
                    kind = KIND_MATCH;
                    idx  = rel_m[IDX_W-1:0];
                end
            end else if (off >= XLATE_BASE && off < XLATE_BASE + WIN_SPAN) begin
                if (rel_x < ENT_L) begin
                    kind = KIND_XLATE;
                    idx  = rel_x[IDX_W-1:0];
                end
            end else if (off >= EXTRA_LO && off <= EXTRA_HI) begin
                kind = KIND_EXTRA;
            end
        end
    end

endmodule

// File: rtl/tlbreg_bank.sv
module tlbreg_bank #(
    parameter int DATA_W  = 32,
    parameter int ENTRIES = 128,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_match,
    input  logic              wr_xlate,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] match_q,
    output logic [DATA_W-1:0] xlate_q
);

    logic [DATA_W-1:1] mtag [ENTRIES];
    logic [DATA_W-1:0] xarr [ENTRIES];
    logic [ENTRIES-1:0] vld;

    // Valid flags: the only state cleared by reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld <= '0;
        end else if (wr_match) begin
            vld[idx] <= wdata[0];
        end
    end

    always_ff @(posedge clk) begin
        if (wr_match) begin
            mtag[idx] <= wdata[DATA_W-1:1];
        end
        if (wr_xlate) begin
            xarr[idx] <= wdata;
        end
    end

    assign match_q = {mtag[idx], vld[idx]};
    assign xlate_q = xarr[idx];

    a_r1_valid_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (vld == '0));

    a_r3_match_store: assert property (@(posedge clk) disable iff (!rst_n)
        wr_match |=> ({mtag[$past(idx)], vld[$past(idx)]} == $past(wdata)));

    a_r4_xlate_store: assert property (@(posedge clk) disable iff (!rst_n)
        wr_xlate |=> (xarr[$past(idx)] == $past(wdata)));

endmodule

// File: rtl/tlbreg_inval_fsm.sv
module tlbreg_inval_fsm
    import tlbreg_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire,
    input  logic [DATA_W-1:0] fire_page,
    input  logic              fire_instr,
    output logic              strobe,
    output logic [DATA_W-1:0] page,
    output logic              instr
);

    inv_state_e state_q;
    inv_state_e state_d;

    // Next-state: T_FIRE, T_REFIRE, T_DONE, T_HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            INV_IDLE:  state_d = fire ? INV_PULSE : INV_IDLE;
            INV_PULSE: state_d = fire ? INV_PULSE : INV_IDLE;
            default:   state_d = INV_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= INV_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Payload captured with each firing
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            page  <= '0;
            instr <= 1'b0;
        end else if (fire) begin
            page  <= fire_page;
            instr <= fire_instr;
        end
    end

    always_comb begin
        strobe = (state_q == INV_PULSE);
    end

    a_r6_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> strobe);

    a_r6_strobe_width: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> !strobe);

    a_r8_flag_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (instr == $past(fire_instr)));

endmodule

// File: rtl/tlbreg_access.sv
module tlbreg_access
    import tlbreg_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ENTRIES   = 128,
    parameter int PAGE_BITS = 13,
    localparam int IDX_W    = $clog2(ENTRIES),
    localparam logic [DATA_W-1:0] PAGE_MASK = ~((DATA_W'(1) << PAGE_BITS) - DATA_W'(1))
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 acc_valid,
    input  logic                 acc_we,
    input  logic [ADDR_W-1:0]    acc_addr,
    input  logic [DATA_W-1:0]    acc_wdata,
    input  logic [DATA_W-1:0]    acc_prev,
    output logic [DATA_W-1:0]    acc_rdata,
    output logic                 inv_valid,
    output logic [DATA_W-1:0]    inv_page,
    output logic                 inv_instr
);

    reg_kind_e         kind;
    logic              sel_instr;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] bank_m [2];
    logic [DATA_W-1:0] bank_x [2];
    logic              do_wr;
    logic              fire;
    logic [DATA_W-1:0] old_match;

    tlbreg_decode #(.ENTRIES(ENTRIES)) u_dec (
        .addr      (acc_addr),
        .kind      (kind),
        .sel_instr (sel_instr),
        .idx       (idx)
    );

    assign do_wr = acc_valid && acc_we;

    // Bank 0: data TLB, bank 1: instruction TLB
    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic hit;
        assign hit = (sel_instr == 1'(b));
        tlbreg_bank #(.DATA_W(DATA_W), .ENTRIES(ENTRIES)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_match (do_wr && hit && (kind == KIND_MATCH)),
            .wr_xlate (do_wr && hit && (kind == KIND_XLATE)),
            .idx      (idx),
            .wdata    (acc_wdata),
            .match_q  (bank_m[b]),
            .xlate_q  (bank_x[b])
        );
    end

    always_comb begin
        old_match = bank_m[sel_instr];
        acc_rdata = acc_prev;
        if (acc_valid) begin
            unique case (kind)
                KIND_MATCH: acc_rdata = bank_m[sel_instr];
                KIND_XLATE: acc_rdata = bank_x[sel_instr];
                KIND_EXTRA: acc_rdata = acc_prev;
                KIND_NONE:  acc_rdata = acc_prev;
                default:    acc_rdata = acc_prev;
            endcase
        end
    end

    assign fire = do_wr && (kind == KIND_MATCH) && !acc_wdata[0];

    tlbreg_inval_fsm #(.DATA_W(DATA_W)) u_inv (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire       (fire),
        .fire_page  (old_match & PAGE_MASK),
        .fire_instr (sel_instr),
        .strobe     (inv_valid),
        .page       (inv_page),
        .instr      (inv_instr)
    );

    a_r7_page_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> ((inv_page & ~PAGE_MASK) == '0));

    a_r5_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && (kind == KIND_EXTRA || kind == KIND_NONE)) |-> (acc_rdata == acc_prev));

    a_r9_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_we && kind != KIND_MATCH) |=> !inv_valid);

    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !inv_valid);

endmodule

// File: tb/sim_tlbreg_access.sv
module sim_tlbreg_access;

    localparam int DW = 32;
    localparam int NE = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_valid = 1'b0;
    logic          acc_we = 1'b0;
    logic [15:0]   acc_addr = '0;
    logic [DW-1:0] acc_wdata = '0;
    logic [DW-1:0] acc_prev = '0;
    logic [DW-1:0] acc_rdata;
    logic          inv_valid;
    logic [DW-1:0] inv_page;
    logic          inv_instr;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    logic [DW-1:0] exp_m [2][NE];
    logic [DW-1:0] exp_t [2][NE];

    always #2 clk = ~clk;

    tlbreg_access #(.DATA_W(DW), .ENTRIES(NE), .PAGE_BITS(13)) u0 (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_we(acc_we),
        .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_prev(acc_prev),
        .acc_rdata(acc_rdata), .inv_valid(inv_valid), .inv_page(inv_page),
        .inv_instr(inv_instr)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(input int g, input int off);
        return 16'((g << 11) + off);
    endfunction

    function automatic logic [DW-1:0] prev_of(input logic [15:0] a);
        return 32'hC0DE_0000 | DW'(a);
    endfunction

    function automatic logic [DW-1:0] expect_rd(input int g, input int off, input logic [DW-1:0] p);
        if (g == 1 || g == 2) begin
            if (off >= 512 && off < 512 + NE) return exp_m[g-1][off-512];
            if (off >= 640 && off < 640 + NE) return exp_t[g-1][off-640];
        end
        return p;
    endfunction

    // Write: inputs set at a falling edge, taken at the next rising edge;
    // returns at the following falling edge with the access removed.
    task automatic wr(input logic [15:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_we = 1'b1; acc_addr = a; acc_wdata = d;
        @(negedge clk);
        acc_valid = 1'b0; acc_we = 1'b0;
        #1;
    endtask

    task automatic rd(input logic [15:0] a, input logic [DW-1:0] p, output logic [DW-1:0] q);
        @(negedge clk);
        acc_valid = 1'b1; acc_we = 1'b0; acc_addr = a; acc_prev = p;
        #1;
        q = acc_rdata;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [DW-1:0] q;
        logic [DW-1:0] old;
        logic [DW-1:0] nv;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: valid bits clear after reset, no strobe
        check("R1 strobe idle", DW'(inv_valid), 0);
        for (int g = 1; g <= 2; g++)
            for (int i = 0; i < NE; i++) begin
                rd(mk(g, 512 + i), 32'hFFFF_FFFF, q);
                check("R1 valid bit", DW'(q[0]), 0);
            end

        // R3/R4/R2: fill both TLBs, no strobe for valid or translate writes (R9)
        for (int g = 1; g <= 2; g++)
            for (int i = 0; i < NE; i++) begin
                exp_m[g-1][i] = (32'h1357_9000 * (g + i + 1)) ^ DW'(i << 13) | 32'h1;
                exp_t[g-1][i] = 32'h0BAD_0000 ^ DW'((g << 20) | (i * 37));
                wr(mk(g, 512 + i), exp_m[g-1][i]);
                check("R9 valid match write no strobe", DW'(inv_valid), 0);
                wr(mk(g, 640 + i), exp_t[g-1][i] & ~32'h1);
                exp_t[g-1][i] = exp_t[g-1][i] & ~32'h1;
                check("R9 translate write no strobe", DW'(inv_valid), 0);
            end

        // R5/R9: junk writes to extra ways, unbacked indexes, other groups
        for (int g = 0; g < 4; g++)
            for (int off = 0; off < 2048; off += ((g == 1 || g == 2) ? 1 : 97)) begin
                if (!((g == 1 || g == 2) &&
                      ((off >= 512 && off < 512 + NE) || (off >= 640 && off < 640 + NE)))) begin
                    wr(mk(g, off), 32'hDEAD_0000 | DW'(off << 1));
                    if ((off % 64) == 0 || (off >= 768 && off <= 1535 && (off % 16) == 0))
                        check("R5/R9 unmapped write no strobe", DW'(inv_valid), 0);
                end
            end

        // R2/R3/R4/R5: full read sweep of every group and offset
        for (int g = 0; g < 4; g++)
            for (int off = 0; off < 2048; off++) begin
                rd(mk(g, off), prev_of(mk(g, off)), q);
                check("R2/R3/R4/R5 read sweep", q, expect_rd(g, off, prev_of(mk(g, off))));
            end

        // R10: idle cycle with write enable ignored
        @(negedge clk);
        acc_valid = 1'b0; acc_we = 1'b1; acc_addr = mk(1, 512); acc_wdata = 32'h0; acc_prev = 32'h5A5A_A5A5;
        #1;
        check("R10 idle passthrough", acc_rdata, 32'h5A5A_A5A5);
        @(negedge clk);
        check("R10 idle no strobe", DW'(inv_valid), 0);
        acc_we = 1'b0;
        rd(mk(1, 512), 0, q);
        check("R10 idle no write", q, exp_m[0][0]);

        // R6/R7/R8: invalidate every entry
        for (int g = 1; g <= 2; g++)
            for (int i = 0; i < NE; i++) begin
                old = exp_m[g-1][i];
                nv  = (32'h8642_0000 + DW'(i * 32'h2001) + DW'(g << 24)) & ~32'h1;
                wr(mk(g, 512 + i), nv);
                check("R6 strobe raised", DW'(inv_valid), 1);
                check("R7 old page", inv_page, old & ~32'h1FFF);
                check("R8 tlb flag", DW'(inv_instr), DW'(g == 2));
                @(negedge clk); #1;
                check("R6 single cycle", DW'(inv_valid), 0);
                exp_m[g-1][i] = nv;
                rd(mk(g, 512 + i), 0, q);
                check("R3 invalidated word stored", q, nv);
                rd(mk(3 - g, 512 + i), 0, q);
                check("R2 other tlb untouched", q, exp_m[2-g][i]);
            end

        // R6/R7/R8: back-to-back invalidations stretch the strobe
        wr(mk(1, 515), 32'hAAAA_E001);
        wr(mk(2, 519), 32'h5555_6001);
        exp_m[0][3] = 32'hAAAA_E001;
        exp_m[1][7] = 32'h5555_6001;
        @(negedge clk);
        acc_valid = 1'b1; acc_we = 1'b1; acc_addr = mk(1, 515); acc_wdata = 32'h0;
        @(negedge clk);
        acc_addr = mk(2, 519); acc_wdata = 32'h2;
        #1;
        check("R6 back-to-back first", DW'(inv_valid), 1);
        check("R7 back-to-back first page", inv_page, 32'hAAAA_E000);
        check("R8 back-to-back first flag", DW'(inv_instr), 0);
        @(negedge clk);
        acc_valid = 1'b0; acc_we = 1'b0;
        #1;
        check("R6 back-to-back second", DW'(inv_valid), 1);
        check("R7 back-to-back second page", inv_page, 32'h5555_6000);
        check("R8 back-to-back second flag", DW'(inv_instr), 1);
        @(negedge clk); #1;
        check("R6 strobe ends", DW'(inv_valid), 0);

        finish_run();
    end

endmodule